// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects a set of level inputs from peripherals and turns them into one normal interrupt line and one fast interrupt line for a small processor. Both lines are active low. Each source has an enable bit, a 3-bit priority, a capture mode (level or rising edge) and a vector word. When the handler reads the vector register, the block picks the enabled, pending, non-fast source with the highest priority. That priority must be strictly above the level currently being serviced. The block returns that source's vector. If no source qualifies, it returns a programmable spurious vector instead.

In normal operation the vector read also acknowledges the chosen source. It pushes the current service level onto an internal stack, so that a later, higher-priority source can nest on top. A write to the end-of-interrupt register pops that stack. A protect mode lets a debugger read the vector with no side effects; the acknowledge then moves to a write of the vector register. A general mask bit silences both interrupt lines but not the wake-up output.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` and `fiq_n` are high and `wake` is low. A vector read returns the spurious vector register's reset value of 0.
- R2: `irq_n` is low exactly when an enabled, pending source other than source 0 has a priority strictly above the current service level. The idle level is below priority 0. A source whose priority equals the current level does not assert `irq_n`.
- R3: Among qualifying sources the highest priority wins. On a tie in priority, the lowest source number wins.
- R4: In normal mode a vector read returns the winner's vector. It pushes the current level and raises the level to the winner's priority. Only a strictly higher priority can then assert `irq_n`, which gives nesting.
- R5: A write to the end-of-interrupt register pops the stack and restores the previous level. A pop on an empty stack leaves the level idle.
- R6: A vector read with no qualifying source returns the spurious vector. It pushes the current level and leaves the level unchanged.
- R7: In protect mode a vector read returns the winner's vector and records the winner. It changes no level and acknowledges nothing, so repeated reads return the same vector. A later write to the vector register performs the push and acknowledge for the recorded source.
- R8: In normal mode a write to the vector register has no effect.
- R9: Capture mode bit 1 selects edge capture: a rising input sets a pending latch that holds after the input drops and is cleared by the acknowledge. In level mode a source is pending only while its input is high.
- R10: While the general mask bit is set, `irq_n` and `fiq_n` are high. `wake` is still high whenever any enabled source is pending.
- R11: Source 0 is the fast source. When it is enabled and high, it drives `fiq_n` low. It never asserts `irq_n` and never wins a vector read.
- R12: The stack holds 8 levels. A push onto a full stack is dropped; the level still updates.
- R13: Register map (word addresses):
  - 0: vector register.
  - 1: end of interrupt.
  - 2: spurious vector.
  - 3: debug control. Bit 0 is the general mask and bit 1 is protect mode.
  - 4: enable. Bit n enables source n.
  - 32+n: configuration of source n. Bits 15:0 hold the vector, bits 18:16 the priority and bit 19 the capture mode.

  A vector read returns the vector in bits 15:0 with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NSRC | Interrupt source lines, active high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | 20 | Write data |
| bus_rdata | output | 20 | Read data, valid in the cycle of the access |
| irq_n | output | 1 | Normal interrupt request, active low |
| fiq_n | output | 1 | Fast interrupt request, active low |
| wake | output | 1 | Any enabled source pending, unaffected by the mask |

## Verification
A source change is registered once. For a level source it reaches `irq_n`, `fiq_n` and `wake` after one clock edge; an edge-captured source takes a second edge to set its latch. The bench therefore waits two falling edges after changing `src_in` before it samples. Read data is combinational from the current state, so the bench captures it shortly after it drives the access, before the rising edge. Level changes caused by a read or a write take effect at that rising edge. The outputs that depend on them are checked at the next falling edge, once the strobe has been released.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int PRIO_W = 3;
  localparam int VEC_W  = 16;
  localparam int RANK_W = PRIO_W + 1;
  localparam int ADDR_W = 6;

  typedef logic [RANK_W-1:0] rank_t;

  typedef struct packed {
    logic              edge_m;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } src_cfg_t;

  localparam int DATA_W = $bits(src_cfg_t);

  localparam logic [ADDR_W-1:0] A_VEC = 6'd0;
  localparam logic [ADDR_W-1:0] A_EOI = 6'd1;
  localparam logic [ADDR_W-1:0] A_SPU = 6'd2;
  localparam logic [ADDR_W-1:0] A_DBG = 6'd3;
  localparam logic [ADDR_W-1:0] A_ENA = 6'd4;
  localparam logic [ADDR_W-1:0] A_CFG = 6'd32;

  localparam int DBG_GMSK = 0;
  localparam int DBG_PROT = 1;

  // Service level of a priority: idle is 0, priority p is p+1.
  function automatic rank_t rank_of(logic [PRIO_W-1:0] p);
    return rank_t'(p) + rank_t'(1);
  endfunction

  function automatic logic [DATA_W-1:0] vec_word(logic [VEC_W-1:0] v);
    return {{(DATA_W-VEC_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/vic_pend.sv
module vic_pend #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic [NSRC-1:0] edge_m,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] s_q, s_q2, latch_q, rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_q  <= '0;
      s_q2 <= '0;
    end else begin
      s_q  <= src_in;
      s_q2 <= s_q;
    end
  end

  assign rise = s_q & ~s_q2;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) latch_q[i] <= 1'b0;
      else        latch_q[i] <= (edge_m[i] & rise[i]) | (latch_q[i] & ~clr[i]);
    end

    assign pend[i] = edge_m[i] ? latch_q[i] : s_q[i];

    // R9: a captured rising edge is pending on the next cycle
    assert_edge_latched_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_m[i] && rise[i]) |=> (latch_q[i] || !edge_m[i]));
  end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NSRC  = 8,
  parameter int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]             elig,
  input  logic [vic_pkg::PRIO_W-1:0]  prio [NSRC],
  input  vic_pkg::rank_t              cur_rank,
  output logic                        found,
  output logic [IDX_W-1:0]            win_idx,
  output vic_pkg::rank_t              win_rank
);
  import vic_pkg::*;

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_rank = cur_rank;
    // Strict compare keeps the lowest index on ties and demands rank above current.
    for (int i = 0; i < NSRC; i++) begin
      if (elig[i] && rank_of(prio[i]) > win_rank) begin
        found    = 1'b1;
        win_idx  = IDX_W'(i);
        win_rank = rank_of(prio[i]);
      end
    end
  end
endmodule

// File: rtl/vic_stack.sv
module vic_stack #(
  parameter int DEPTH = 8,
  parameter int RW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [RW-1:0] new_rank,
  output logic [RW-1:0] cur_rank,
  output logic          full,
  output logic          empty
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [RW-1:0]  mem [DEPTH];
  logic [SPW-1:0] sp, sp_m1;

  assign full  = (sp == SPW'(DEPTH));
  assign empty = (sp == '0);
  assign sp_m1 = sp - SPW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp       <= '0;
      cur_rank <= '0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (push) begin
      if (!full) begin
        mem[sp[IW-1:0]] <= cur_rank;
        sp              <= sp + SPW'(1);
      end
      cur_rank <= new_rank;
    end else if (pop) begin
      if (!empty) begin
        cur_rank <= mem[sp_m1[IW-1:0]];
        sp       <= sp_m1;
      end else begin
        cur_rank <= '0;
      end
    end
  end

  assert_full_push_dropped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> (sp == $past(sp)));

  assert_empty_pop_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> (cur_rank == '0 && sp == '0));
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int FAST_IDX = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_in,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_n,
  output logic              fiq_n,
  output logic              wake
);
  localparam int IDX_W = $clog2(NSRC);
  localparam int DEPTH = 1 << PRIO_W;

  src_cfg_t           cfg [NSRC];
  logic [NSRC-1:0]    ena_q;
  logic [VEC_W-1:0]   spu_q;
  logic               gmsk_q, prot_q;
  logic               rec_real_q;
  logic [IDX_W-1:0]   rec_idx_q;
  rank_t              rec_rank_q;

  logic rd_vec, wr_vec, wr_eoi, wr_spu, wr_dbg, wr_ena;
  assign rd_vec = bus_sel && !bus_wr && bus_addr == A_VEC;
  assign wr_vec = bus_sel &&  bus_wr && bus_addr == A_VEC;
  assign wr_eoi = bus_sel &&  bus_wr && bus_addr == A_EOI;
  assign wr_spu = bus_sel &&  bus_wr && bus_addr == A_SPU;
  assign wr_dbg = bus_sel &&  bus_wr && bus_addr == A_DBG;
  assign wr_ena = bus_sel &&  bus_wr && bus_addr == A_ENA;

  // Per-source configuration registers
  logic [NSRC-1:0]   edge_m;
  logic [PRIO_W-1:0] prio [NSRC];
  for (genvar i = 0; i < NSRC; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg[i] <= '0;
      else if (bus_sel && bus_wr && bus_addr == A_CFG + ADDR_W'(i))
        cfg[i] <= src_cfg_t'(bus_wdata);
    end
    assign edge_m[i] = cfg[i].edge_m;
    assign prio[i]   = cfg[i].prio;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= '0;
      spu_q  <= '0;
      gmsk_q <= 1'b0;
      prot_q <= 1'b0;
    end else begin
      if (wr_ena) ena_q <= bus_wdata[NSRC-1:0];
      if (wr_spu) spu_q <= bus_wdata[VEC_W-1:0];
      if (wr_dbg) begin
        gmsk_q <= bus_wdata[DBG_GMSK];
        prot_q <= bus_wdata[DBG_PROT];
      end
    end
  end

  // Pending state
  logic [NSRC-1:0] pend, clr, elig, fast_mask;
  vic_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_in(src_in),
    .edge_m(edge_m), .clr(clr), .pend(pend)
  );

  assign fast_mask = NSRC'(1) << FAST_IDX;
  assign elig      = pend & ena_q & ~fast_mask;

  // Arbitration against the current service level
  rank_t            cur_rank, win_rank;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  vic_arb #(.NSRC(NSRC), .IDX_W(IDX_W)) u_arb (
    .elig(elig), .prio(prio), .cur_rank(cur_rank),
    .found(found), .win_idx(win_idx), .win_rank(win_rank)
  );

  // Acknowledge event: read in normal mode, vector write in protect mode
  logic             ack_ev, ack_real, st_full, st_empty;
  logic [IDX_W-1:0] ack_idx;
  rank_t            ack_rank, new_rank;

  assign ack_ev   = prot_q ? wr_vec     : rd_vec;
  assign ack_real = prot_q ? rec_real_q : found;
  assign ack_idx  = prot_q ? rec_idx_q  : win_idx;
  assign ack_rank = prot_q ? rec_rank_q : win_rank;
  assign new_rank = ack_real ? ack_rank : cur_rank;
  assign clr      = (ack_ev && ack_real) ? (NSRC'(1) << ack_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_real_q <= 1'b0;
      rec_idx_q  <= '0;
      rec_rank_q <= '0;
    end else if (rd_vec) begin
      rec_real_q <= found;
      rec_idx_q  <= win_idx;
      rec_rank_q <= win_rank;
    end else if (ack_ev) begin
      rec_real_q <= 1'b0;
    end
  end

  vic_stack #(.DEPTH(DEPTH), .RW(RANK_W)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack_ev), .pop(wr_eoi),
    .new_rank(new_rank), .cur_rank(cur_rank),
    .full(st_full), .empty(st_empty)
  );

  // Outputs
  logic irq_req, fiq_req;
  assign irq_req   = found;
  assign fiq_req   = pend[FAST_IDX] & ena_q[FAST_IDX];
  assign wake      = |(pend & ena_q);
  assign irq_n     = ~(irq_req & ~gmsk_q);
  assign fiq_n     = ~(fiq_req & ~gmsk_q);
  assign bus_rdata = rd_vec ? vec_word(found ? cfg[win_idx].vec : spu_q) : '0;

  // Assertions
  assert_ack_raises_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && ack_real) |=> (cur_rank == $past(ack_rank)));

  assert_spurious_keeps_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_ev && !ack_real) |=> (cur_rank == $past(cur_rank)));

  assert_protect_read_inert_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_q && rd_vec) |=> $stable(cur_rank));

  assert_vec_write_inert_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!prot_q && wr_vec) |=> $stable(cur_rank));

  assert_mask_spares_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (gmsk_q && fiq_req) |-> (wake && irq_n && fiq_n));

  assert_fast_never_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (win_idx != IDX_W'(FAST_IDX)));

  assert_win_above_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> (win_rank > cur_rank));
endmodule

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam logic [19:0] SPV = 20'h0DEAD;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [19:0] bus_wdata = '0;
  logic [19:0] bus_rdata;
  logic        irq_n, fiq_n, wake;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl #(.NSRC(NSRC)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_n(irq_n), .fiq_n(fiq_n), .wake(wake)
  );

  task automatic chk(string tag, logic [19:0] act, logic [19:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [19:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    #1;
  endtask

  task automatic rd_vec(output logic [19:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 6'd0;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
    #1;
  endtask

  task automatic eoi();
    wr(6'd1, '0);
  endtask

  task automatic set_src(logic [7:0] s);
    @(negedge clk);
    src = s;
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic cfg(int n, logic [2:0] p, logic edge_sel);
    wr(6'd32 + 6'(n), {edge_sel, p, 16'h0100 + 16'(n)});
  endtask

  task automatic t_reset();
    logic [19:0] v;
    chk("R1 irq_n", irq_n, 1);
    chk("R1 fiq_n", fiq_n, 1);
    chk("R1 wake", wake, 0);
    rd_vec(v);
    chk("R1 spurious reset value", v, 0);
    eoi();
  endtask

  task automatic t_basic();
    logic [19:0] v;
    cfg(3, 3'd2, 0); cfg(5, 3'd2, 0); cfg(6, 3'd5, 0); cfg(1, 3'd0, 0);
    set_src(8'h08);
    chk("R2 irq asserted", irq_n, 0);
    rd_vec(v);
    chk("R4 R13 vector", v, 20'h00103);
    chk("R4 level raised", irq_n, 1);
    set_src(8'h28);
    chk("R2 equal prio blocked", irq_n, 1);
    set_src(8'h68);
    chk("R4 nesting higher prio", irq_n, 0);
    rd_vec(v);
    chk("R4 nested vector", v, 20'h00106);
    chk("R4 nested level", irq_n, 1);
    eoi();
    chk("R5 pop restores level", irq_n, 0);
    set_src(8'h00);
    eoi();
    eoi();
    set_src(8'h02);
    chk("R5 empty pop idle", irq_n, 0);
    set_src(8'h00);
  endtask

  task automatic t_tie();
    logic [19:0] v;
    cfg(2, 3'd1, 0); cfg(4, 3'd1, 0); cfg(7, 3'd6, 0);
    set_src(8'h14);
    rd_vec(v);
    chk("R3 tie lowest index", v, 20'h00102);
    eoi();
    set_src(8'h94);
    rd_vec(v);
    chk("R3 highest prio", v, 20'h00107);
    eoi();
    set_src(8'h00);
  endtask

  task automatic t_spur();
    logic [19:0] v;
    cfg(1, 3'd3, 0);
    set_src(8'h02);
    chk("R6 irq before drop", irq_n, 0);
    set_src(8'h00);
    chk("R9 level source gone", irq_n, 1);
    rd_vec(v);
    chk("R6 spurious vector", v, SPV);
    set_src(8'h02);
    chk("R6 level unchanged", irq_n, 0);
    set_src(8'h00);
    eoi();
  endtask

  task automatic t_edge();
    logic [19:0] v;
    cfg(4, 3'd2, 1);
    @(negedge clk); src = 8'h10;
    @(negedge clk); src = 8'h00;
    repeat (2) @(negedge clk);
    #1;
    chk("R9 edge held irq", irq_n, 0);
    chk("R9 edge held wake", wake, 1);
    rd_vec(v);
    chk("R9 edge vector", v, 20'h00104);
    eoi();
    chk("R9 latch cleared", irq_n, 1);
    cfg(4, 3'd1, 0);
  endtask

  task automatic t_protect();
    logic [19:0] v;
    cfg(3, 3'd2, 0);
    wr(6'd3, 20'h2);
    set_src(8'h08);
    rd_vec(v);
    chk("R7 protect vector", v, 20'h00103);
    chk("R7 no ack on read", irq_n, 0);
    rd_vec(v);
    chk("R7 repeat vector", v, 20'h00103);
    wr(6'd0, '0);
    chk("R7 write acks", irq_n, 1);
    eoi();
    chk("R7 eoi after ack", irq_n, 0);
    set_src(8'h00);
    wr(6'd3, 20'h0);
  endtask

  task automatic t_nwrite();
    logic [19:0] v;
    set_src(8'h08);
    wr(6'd0, '0);
    chk("R8 write inert", irq_n, 0);
    rd_vec(v);
    chk("R8 vector after write", v, 20'h00103);
    eoi();
    set_src(8'h00);
  endtask

  task automatic t_mask();
    wr(6'd3, 20'h1);
    set_src(8'h09);
    chk("R10 irq masked", irq_n, 1);
    chk("R10 fiq masked", fiq_n, 1);
    chk("R10 wake kept", wake, 1);
    wr(6'd3, 20'h0);
    chk("R10 irq unmasked", irq_n, 0);
    chk("R10 fiq unmasked", fiq_n, 0);
    set_src(8'h00);
  endtask

  task automatic t_fast();
    logic [19:0] v;
    cfg(0, 3'd7, 0);
    set_src(8'h01);
    chk("R11 fiq low", fiq_n, 0);
    chk("R11 irq high", irq_n, 1);
    rd_vec(v);
    chk("R11 not a vector", v, SPV);
    eoi();
    set_src(8'h00);
    chk("R11 fiq released", fiq_n, 1);
  endtask

  task automatic t_stack();
    logic [19:0] v;
    cfg(7, 3'd7, 0); cfg(1, 3'd0, 0);
    set_src(8'h80);
    rd_vec(v);
    chk("R12 top vector", v, 20'h00107);
    set_src(8'h00);
    for (int k = 0; k < 8; k++) rd_vec(v);
    chk("R12 spurious at top", v, SPV);
    set_src(8'h02);
    chk("R12 level held", irq_n, 1);
    for (int k = 0; k < 7; k++) eoi();
    chk("R12 seven pops still high", irq_n, 1);
    eoi();
    chk("R12 eighth pop idle", irq_n, 0);
    set_src(8'h00);
    eoi();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    wr(6'd2, SPV);
    wr(6'd4, 20'hFF);
    t_basic();
    t_tie();
    t_spur();
    t_edge();
    t_protect();
    t_nwrite();
    t_mask();
    t_fast();
    t_stack();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule